// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block is the timing core of a small Harvard processor with 14-bit instruction words. It divides the incoming clock into four rotating phases, so one instruction cycle lasts four clocks. While one instruction executes, the next word is fetched from program memory. The fetched word enters the instruction register at the last phase, ready to execute in the following cycle. The block also times the data-memory strobes for the executing instruction: the operand read falls in the second phase and the destination write in the fourth.

The sequencer keeps a 13-bit fetch counter. The counter is masked to the implemented program-memory size, so addresses past the end wrap to the start. The decoder, which is outside this block, reports a taken jump, a subroutine call or a return for the instruction that is executing. The sequencer then redirects fetch and replaces the word already fetched with a no-op. Every redirection therefore costs one extra cycle. An interrupt request is accepted only at a cycle boundary. It sends fetch to 0004h and pushes the address of the discarded word onto an eight-entry return stack.

Top module: `qphase_fetch_seq`

## Requirements
- R1: `phase_o` is one-hot, with bit 0 for Q1 through bit 3 for Q4. It advances one bit per clock in the order Q1, Q2, Q3, Q4, then back to Q1.
- R2: The fetch address on `pm_addr_o` changes only at the end of Q1. `pm_rd_o` is high during Q4. The word on `pm_data_i` is latched into `ir_o` at the end of Q4, and `exec_valid_o` is raised for the next cycle.
- R3: `dm_rd_o` pulses only in Q2 and `dm_wr_o` only in Q4. Each pulses only when `exec_valid_o` is high and `dec_rd_i` or `dec_wr_i`, respectively, is high.
- R4: A taken jump (`br_take_i` high during Q4 of a valid cycle) makes `ir_o` the no-op word 14'h0000 and drops `exec_valid_o` for the next cycle. The next fetch then comes from `br_target_i`.
- R5: A call (`br_take_i` and `br_call_i`) pushes the address of the word being fetched in that cycle. A return (`br_ret_i`, which has priority over a jump) pops the stack, redirects fetch to the popped address and flushes like R4. Nested calls return in last-in, first-out order.
- R6: `irq_i` is sampled at the end of Q4. When it is accepted, the fetched word is flushed to a no-op, the address of that word is pushed, and the next fetch comes from 0004h.
- R7: A taken jump or return at the same boundary as an interrupt request takes priority. A request that is still present is accepted at the next boundary, even if that cycle executes a no-op.
- R8: While `exec_valid_o` is low, the jump, call, return and data-memory request inputs have no effect.
- R9: With `MEM_WORDS` = 2048, fetch wraps from 07FFh to 0000h, and a target of 1805h fetches from 0005h.
- R10: While `rst_ni` is low, `phase_o` is Q1, `pm_addr_o` is 0, `ir_o` is the no-op and `exec_valid_o` is low. The first cycle after reset fetches from 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, four per instruction cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pm_addr_o | output | 13 | Program-memory fetch address |
| pm_rd_o | output | 1 | Fetch latch strobe (Q4) |
| pm_data_i | input | 14 | Program-memory word |
| phase_o | output | 4 | One-hot phase Q1..Q4 |
| ir_o | output | 14 | Instruction register |
| exec_valid_o | output | 1 | Executing slot holds a real instruction |
| dm_rd_o | output | 1 | Data-memory operand read strobe |
| dm_wr_o | output | 1 | Data-memory destination write strobe |
| dec_rd_i | input | 1 | Executing instruction reads data memory |
| dec_wr_i | input | 1 | Executing instruction writes data memory |
| br_take_i | input | 1 | Executing instruction redirects fetch |
| br_call_i | input | 1 | Redirect is a call (push return address) |
| br_ret_i | input | 1 | Executing instruction returns (pop) |
| br_target_i | input | 13 | Jump or call target |
| irq_i | input | 1 | Interrupt request, level |

## Verification
A taken jump and an interrupt request can both be presented at the same Q4 boundary. To provoke this, the bench holds `irq_i` high through a cycle whose instruction jumps to an out-of-range target. It then checks two things: the next fetch address is the masked target rather than 0004h, and in the following no-op cycle the still-pending request is taken, pushing the target address. A later return is expected to come back to that masked target, which shows the address pushed at the deferred interrupt.

// File: rtl/qfetch_pkg.sv
package qfetch_pkg;
  localparam int unsigned PC_W    = 13;
  localparam int unsigned INSTR_W = 14;
  localparam int unsigned NPHASE  = 4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;

  localparam logic [INSTR_W-1:0] NOP_WORD  = '0;
  localparam logic [PC_W-1:0]    RESET_VEC = 13'h0000;
  localparam logic [PC_W-1:0]    IRQ_VEC   = 13'h0004;
endpackage

// File: rtl/qf_phase_gen.sv
module qf_phase_gen
  import qfetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [NPHASE-1:0] ph_hot_o
);
  qphase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_Q1;
    else         ph_q <= qphase_e'(ph_q + 2'd1);
  end

  for (genvar g = 0; g < NPHASE; g++) begin : g_hot
    assign ph_hot_o[g] = (ph_q == qphase_e'(g));
  end
endmodule

// File: rtl/qf_pc_unit.sv
module qf_pc_unit
  import qfetch_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 2048
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            q1_end_i,
  input  logic            q4_end_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] redir_addr_i,
  output logic [PC_W-1:0] fetch_addr_o
);
  localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(MEM_WORDS - 1);

  logic [PC_W-1:0] pc_q, fa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_VEC;
      fa_q <= RESET_VEC;
    end else if (q1_end_i) begin
      fa_q <= pc_q;
      pc_q <= (pc_q + 1'b1) & ADDR_MASK;
    end else if (q4_end_i && redirect_i) begin
      pc_q <= redir_addr_i & ADDR_MASK;
    end
  end

  assign fetch_addr_o = fa_q;
endmodule

// File: rtl/qf_ret_stack.sv
module qf_ret_stack
  import qfetch_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_val_i,
  output logic [PC_W-1:0] top_o
);
  // DEPTH must be a power of two; the pointer wraps silently
  localparam int unsigned SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_dn;
  logic [PC_W-1:0] ent [DEPTH];

  assign sp_dn = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_dn;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ent[g] <= '0;
      else if (push_i && sp_q == SP_W'(g))    ent[g] <= push_val_i;
    end
  end

  assign top_o = ent[sp_dn];
endmodule

// File: rtl/qf_ir_stage.sv
module qf_ir_stage
  import qfetch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               q4_end_i,
  input  logic               flush_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic               valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_o    <= NOP_WORD;
      valid_o <= 1'b0;
    end else if (q4_end_i) begin
      ir_o    <= flush_i ? NOP_WORD : word_i;
      valid_o <= ~flush_i;
    end
  end
endmodule

// File: rtl/qphase_fetch_seq.sv
module qphase_fetch_seq
  import qfetch_pkg::*;
#(
  parameter int unsigned MEM_WORDS   = 2048,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    pm_addr_o,
  output logic               pm_rd_o,
  input  logic [INSTR_W-1:0] pm_data_i,
  output logic [NPHASE-1:0]  phase_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               exec_valid_o,
  output logic               dm_rd_o,
  output logic               dm_wr_o,
  input  logic               dec_rd_i,
  input  logic               dec_wr_i,
  input  logic               br_take_i,
  input  logic               br_call_i,
  input  logic               br_ret_i,
  input  logic [PC_W-1:0]    br_target_i,
  input  logic               irq_i
);
  logic [NPHASE-1:0] ph_hot;
  logic              q1_end, q4_end;
  logic              dec_ret, dec_jmp, dec_call, irq_take, redirect;
  logic [PC_W-1:0]   redir_addr, stk_top, fetch_addr;

  qf_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_hot_o (ph_hot)
  );

  assign q1_end = ph_hot[0];
  assign q4_end = ph_hot[NPHASE-1];

  // decoder controls only count for a real instruction; return beats jump
  assign dec_ret  = exec_valid_o & br_ret_i;
  assign dec_jmp  = exec_valid_o & br_take_i & ~br_ret_i;
  assign dec_call = dec_jmp & br_call_i;
  assign irq_take = irq_i & ~(dec_ret | dec_jmp);
  assign redirect = dec_ret | dec_jmp | irq_take;

  always_comb begin
    if (dec_ret)      redir_addr = stk_top;
    else if (dec_jmp) redir_addr = br_target_i;
    else              redir_addr = IRQ_VEC;
  end

  qf_pc_unit #(.MEM_WORDS(MEM_WORDS)) u_pc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .q1_end_i     (q1_end),
    .q4_end_i     (q4_end),
    .redirect_i   (redirect),
    .redir_addr_i (redir_addr),
    .fetch_addr_o (fetch_addr)
  );

  qf_ret_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (q4_end & (dec_call | irq_take)),
    .pop_i      (q4_end & dec_ret),
    .push_val_i (fetch_addr),
    .top_o      (stk_top)
  );

  qf_ir_stage u_ir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .q4_end_i (q4_end),
    .flush_i  (redirect),
    .word_i   (pm_data_i),
    .ir_o     (ir_o),
    .valid_o  (exec_valid_o)
  );

  assign pm_addr_o = fetch_addr;
  assign pm_rd_o   = q4_end;
  assign phase_o   = ph_hot;
  assign dm_rd_o   = ph_hot[1] & exec_valid_o & dec_rd_i;
  assign dm_wr_o   = q4_end & exec_valid_o & dec_wr_i;
endmodule

// File: rtl/qphase_fetch_seq_chk.sv
module qphase_fetch_seq_chk
  import qfetch_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 2048
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PC_W-1:0]    pm_addr_o,
  input logic               pm_rd_o,
  input logic [NPHASE-1:0]  phase_o,
  input logic [INSTR_W-1:0] ir_o,
  input logic               exec_valid_o,
  input logic               dm_rd_o,
  input logic               dm_wr_o,
  input logic               dec_rd_i,
  input logic               dec_wr_i,
  input logic               br_take_i,
  input logic               br_ret_i,
  input logic [PC_W-1:0]    br_target_i,
  input logic               irq_i
);
  localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

  a_r1_phase_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);
  a_r1_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3] |=> phase_o[0]);
  a_r1_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[0] |=> phase_o[1]);
  a_r2_addr_only_q1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |=> $stable(pm_addr_o));
  a_r2_ir_only_q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_rd_o |=> $stable(ir_o));
  a_r3_rd_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_rd_o |-> (phase_o[1] && exec_valid_o && dec_rd_i));
  a_r3_wr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_wr_o |-> (phase_o[3] && exec_valid_o && dec_wr_i));
  a_r4_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && exec_valid_o && (br_take_i || br_ret_i))
      |=> (ir_o == NOP_WORD && !exec_valid_o));
  a_r6_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && irq_i && !(exec_valid_o && (br_take_i || br_ret_i)))
      |-> ##2 (pm_addr_o == IRQ_VEC));
  a_r7_branch_beats_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && exec_valid_o && br_take_i && !br_ret_i)
      |-> ##2 (pm_addr_o == ($past(br_target_i, 2) & MASK)));
  a_r9_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pm_addr_o) < MEM_WORDS);
endmodule

bind qphase_fetch_seq qphase_fetch_seq_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pm_addr_o    (pm_addr_o),
  .pm_rd_o      (pm_rd_o),
  .phase_o      (phase_o),
  .ir_o         (ir_o),
  .exec_valid_o (exec_valid_o),
  .dm_rd_o      (dm_rd_o),
  .dm_wr_o      (dm_wr_o),
  .dec_rd_i     (dec_rd_i),
  .dec_wr_i     (dec_wr_i),
  .br_take_i    (br_take_i),
  .br_ret_i     (br_ret_i),
  .br_target_i  (br_target_i),
  .irq_i        (irq_i)
);

// File: tb/qphase_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module qphase_fetch_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [12:0] pm_addr_o;
  logic        pm_rd_o;
  logic [13:0] pm_data_i;
  logic [3:0]  phase_o;
  logic [13:0] ir_o;
  logic        exec_valid_o, dm_rd_o, dm_wr_o;
  logic        dec_rd_i, dec_wr_i, br_take_i, br_call_i, br_ret_i, irq_i;
  logic [12:0] br_target_i;

  always #4 clk_i = ~clk_i;

  function automatic logic [13:0] word_of(input logic [12:0] a);
    return 14'h2000 | {1'b0, a};
  endfunction

  assign pm_data_i = word_of(pm_addr_o);

  qphase_fetch_seq dut_i (.*);

  typedef struct packed {
    logic        br, call, ret, irq, rd, wr, ev;
    logic [12:0] tgt, fa;
    logic        enop;
    logic [12:0] ea;
  } row_t;

  // per instruction cycle: controls, expected exec_valid, fetch address, IR after
  localparam row_t TBL [23] = '{
    '{0,0,0,0,0,0,0,13'h000,13'h000,0,13'h000}, // R10 first fetch at 0
    '{0,0,0,0,1,0,1,13'h000,13'h001,0,13'h001}, // R3 read
    '{0,0,0,0,0,1,1,13'h000,13'h002,0,13'h002}, // R3 write
    '{1,0,0,0,1,1,1,13'h100,13'h003,1,13'h000}, // R4 jump
    '{0,0,0,0,1,1,0,13'h000,13'h100,0,13'h100}, // R8 no strobes in no-op slot
    '{1,1,0,0,0,0,1,13'h200,13'h101,1,13'h000}, // R5 call, push 101
    '{0,0,0,0,0,0,0,13'h000,13'h200,0,13'h200},
    '{0,0,0,1,0,0,1,13'h000,13'h201,1,13'h000}, // R6 irq, push 201
    '{0,0,0,0,0,0,0,13'h000,13'h004,0,13'h004}, // R6 vector
    '{0,0,1,0,0,0,1,13'h000,13'h005,1,13'h000}, // R5 return
    '{0,0,0,0,0,0,0,13'h000,13'h201,0,13'h201},
    '{0,0,1,0,0,0,1,13'h000,13'h202,1,13'h000}, // R5 nested return
    '{0,0,0,0,0,0,0,13'h000,13'h101,0,13'h101},
    '{1,0,0,1,0,0,1,13'h1805,13'h102,1,13'h000}, // R7 jump and irq together
    '{0,0,0,1,0,0,0,13'h000,13'h005,1,13'h000}, // R7 R9 masked target, irq now
    '{0,0,0,0,0,0,0,13'h000,13'h004,0,13'h004},
    '{0,0,1,0,0,0,1,13'h000,13'h005,1,13'h000}, // R7 return to pushed 005
    '{0,0,0,0,0,0,0,13'h000,13'h005,0,13'h005},
    '{1,0,0,0,0,0,1,13'h7FE,13'h006,1,13'h000},
    '{1,1,0,0,1,1,0,13'h300,13'h7FE,0,13'h7FE}, // R8 jump/call ignored
    '{0,0,0,0,1,0,1,13'h000,13'h7FF,0,13'h7FF},
    '{0,0,0,0,0,0,1,13'h000,13'h000,0,13'h000}, // R9 wrap
    '{0,0,0,0,0,0,1,13'h000,13'h001,0,13'h001}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_icycle(input row_t r);
    br_take_i   = r.br;  br_call_i = r.call; br_ret_i = r.ret;
    irq_i       = r.irq; dec_rd_i  = r.rd;   dec_wr_i = r.wr;
    br_target_i = r.tgt;
    for (int k = 0; k < 4; k++) begin
      chk("R1 phase", 32'(phase_o), 32'(4'b1 << k));
      chk("R2 pm_rd", 32'(pm_rd_o), 32'(k == 3));
      chk("R3 R8 dm_rd", 32'(dm_rd_o), 32'(k == 1 && r.ev && r.rd));
      chk("R3 R8 dm_wr", 32'(dm_wr_o), 32'(k == 3 && r.ev && r.wr));
      if (k == 1) begin
        chk("R2 R9 fetch addr", 32'(pm_addr_o), 32'(r.fa));
        chk("R4 exec_valid", 32'(exec_valid_o), 32'(r.ev));
      end
      @(negedge clk_i);
    end
    chk("R2 R4 R5 R6 R7 ir", 32'(ir_o), r.enop ? 32'h0 : 32'(word_of(r.ea)));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    {br_take_i, br_call_i, br_ret_i, irq_i, dec_rd_i, dec_wr_i} = '0;
    br_target_i = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 phase", 32'(phase_o), 32'h1);
    chk("R10 addr", 32'(pm_addr_o), 32'h0);
    chk("R10 ir", 32'(ir_o), 32'h0);
    chk("R10 valid", 32'(exec_valid_o), 32'h0);
    rst_ni = 1'b1;

    foreach (TBL[i]) run_icycle(TBL[i]);

    // R10 reset in mid-cycle
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 async phase", 32'(phase_o), 32'h1);
    chk("R10 async addr", 32'(pm_addr_o), 32'h0);
    chk("R10 async ir", 32'(ir_o), 32'h0);
    chk("R10 async valid", 32'(exec_valid_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_icycle('{0,0,0,0,0,0,0,13'h000,13'h000,0,13'h000});
    run_icycle('{0,0,0,0,1,1,1,13'h000,13'h001,0,13'h001});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule